// File: doc/BRIEF.md
# Stream Payload Width Adapter

The adapter joins two valid/ready streams whose payloads differ in width. When the output is wider than the input, consecutive input beats are gathered and sent as one wide output beat. When the output is narrower, each input word is sent as a run of narrow output beats. When both widths are equal, the stream passes straight through with no storage.

The slice order is set at elaboration. In lower-first order the earliest beat or slice sits at bit 0. In higher-first order it sits at the most significant end. A padding switch accepts width pairs where neither width divides the other. With padding off, such a pair is rejected during elaboration. With padding on, the bits past the end of the input word are filled with zeros when a word is split, and the surplus bits of the final input beat are discarded when beats are packed.

Top module: `stream_width_adapter`

## Requirements
- R1: With outW > inW, every ceil(outW/inW) consecutive accepted input beats leave as one output beat, in order. The output beat becomes valid the cycle after the last of those input beats is accepted.
- R2: With outW < inW, every accepted input word leaves as ceil(inW/outW) consecutive output beats, in order. The first slice is valid the cycle after the word is accepted.
- R3: With HIGH_FIRST = 0, the earliest input beat of a packed word occupies bits starting at bit 0, and the first slice of a split word is taken from bit 0 upward.
- R4: With HIGH_FIRST = 1, the earliest input beat occupies the most significant end of the packed word, and the first slice of a split word is taken from the most significant end.
- R5: With PAD = 1, non-multiple widths are accepted. In packing, the concatenated beats are cut to outW bits, dropping bits of the final beat. In splitting, the word is extended with zeros at the end that is emitted last, so the missing bits of the final slice read as zero.
- R6: With outW = inW, outValid equals inValid, inReady equals outReady and outData equals inData in the same cycle.
- R7: When packing, inReady stays high while slices are gathered. Once a full word is held and outReady is low, inReady stays low. It is high again in the cycle outReady is high, so a new beat may enter as the word leaves.
- R8: When splitting, inReady is high while no word is held. While a word is held, inReady is high only in a cycle in which the final slice leaves (outReady high on the last slice).
- R9: Once outValid is high and outReady is low, outValid stays high and outData is unchanged in the next cycle.
- R10: During and right after reset, outValid is low and no beat or slice is held. When packing or splitting, inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Adapter takes the input beat this cycle |
| inData | input | W_IN | Input payload |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Downstream takes the output beat this cycle |
| outData | output | W_OUT | Output payload |

## Verification
The assertions assume the upstream side obeys the stream rules: once inValid is raised, it stays high and inData stays unchanged until a cycle in which inReady is also high. The bench drivers change inValid and inData only after a transfer, or while inValid is low. A stalled beat is re-offered unchanged. Nine instances sweep every mode: packing, splitting, both slice orders, padded and exact widths, and pass-through. Each instance runs under random valid and ready patterns after an opening phase with the output held back.

// File: rtl/swa_pkg.sv
`timescale 1ns/1ps
package swa_pkg;

  typedef enum logic [1:0] {
    MODE_PASS,
    MODE_PACK,
    MODE_UNPACK
  } adaptMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;  // an input beat is taken this cycle
    logic emit;     // an output beat leaves this cycle
  } swaStrobes_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/swa_control.sv
`timescale 1ns/1ps
module swa_control
  import swa_pkg::*;
#(
  parameter adaptMode_e MODE   = MODE_PACK,
  parameter int         NSLICE = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output swaStrobes_t strobes
);

  localparam int IDX_W = (NSLICE > 1) ? $clog2(NSLICE) : 1;

  if (MODE == MODE_PACK) begin : g_pack
    logic             full;
    logic [IDX_W-1:0] beatCnt;
    logic             lastBeat;
    logic             inFire;
    logic             outFire;

    assign lastBeat = (beatCnt == IDX_W'(NSLICE - 1));
    assign outValid = full;
    assign inReady  = !full || outReady;
    assign inFire   = inValid && inReady;
    assign outFire  = full && outReady;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        full    <= 1'b0;
        beatCnt <= '0;
      end else begin
        if (inFire) beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
        if (inFire && lastBeat) full <= 1'b1;
        else if (outFire)       full <= 1'b0;
      end
    end

    assign strobes.capture = inFire;
    assign strobes.emit    = outFire;

    // R1: the last gathered beat makes a word valid next cycle
    a_r1_word_after_last: assert property (@(posedge clk) disable iff (!rstN)
      inValid && inReady && lastBeat |=> outValid);
    // R7: a leaving word always frees room for an offered beat
    a_r7_refill_on_fire: assert property (@(posedge clk) disable iff (!rstN)
      outValid && outReady && inValid |-> inReady);
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
      {1'b0, beatCnt} < (IDX_W + 1)'(NSLICE));

  end else if (MODE == MODE_UNPACK) begin : g_unpack
    logic             full;
    logic [IDX_W-1:0] beatCnt;
    logic             lastBeat;
    logic             inFire;
    logic             outFire;

    assign lastBeat = (beatCnt == IDX_W'(NSLICE - 1));
    assign outValid = full;
    assign inReady  = !full || (outReady && lastBeat);
    assign inFire   = inValid && inReady;
    assign outFire  = full && outReady;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        full    <= 1'b0;
        beatCnt <= '0;
      end else if (inFire) begin
        full    <= 1'b1;
        beatCnt <= '0;
      end else if (outFire) begin
        if (lastBeat) full    <= 1'b0;
        else          beatCnt <= beatCnt + 1'b1;
      end
    end

    assign strobes.capture = inFire;
    assign strobes.emit    = outFire;

    // R2: an accepted word starts with its first slice next cycle
    a_r2_first_slice: assert property (@(posedge clk) disable iff (!rstN)
      inValid && inReady |=> outValid && (beatCnt == '0));
    // R8: while a word is held, a new one enters only as the output moves
    a_r8_accept_on_drain: assert property (@(posedge clk) disable iff (!rstN)
      inValid && inReady && outValid |-> outReady);
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
      {1'b0, beatCnt} < (IDX_W + 1)'(NSLICE));

  end else begin : g_pass
    logic unusedClocking;
    assign unusedClocking  = clk ^ rstN;
    assign inReady         = outReady;
    assign outValid        = inValid;
    assign strobes.capture = inValid && outReady;
    assign strobes.emit    = inValid && outReady;
  end

endmodule

// File: rtl/swa_datapath.sv
`timescale 1ns/1ps
module swa_datapath
  import swa_pkg::*;
#(
  parameter int         W_IN       = 8,
  parameter int         W_OUT      = 16,
  parameter int         NSLICE     = 2,
  parameter bit         HIGH_FIRST = 1'b0,
  parameter adaptMode_e MODE       = MODE_PACK
) (
  input  logic              clk,
  input  logic              rstN,
  input  swaStrobes_t       strobes,
  input  logic [W_IN-1:0]   inData,
  output logic [W_OUT-1:0]  outData
);

  if (MODE == MODE_PACK) begin : g_pack
    localparam int REG_W = NSLICE * W_IN;
    logic [REG_W-1:0] shiftReg;
    logic             unusedEmit;
    assign unusedEmit = strobes.emit;

    if (HIGH_FIRST) begin : g_hi
      // new beats enter at the bottom, so the earliest one rises to the top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shiftReg <= '0;
        else if (strobes.capture) shiftReg <= {shiftReg[REG_W-W_IN-1:0], inData};
      end
      assign outData = shiftReg[REG_W-1 -: W_OUT];
    end else begin : g_lo
      // new beats enter at the top, so the earliest one sinks to bit 0
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shiftReg <= '0;
        else if (strobes.capture) shiftReg <= {inData, shiftReg[REG_W-1:W_IN]};
      end
      assign outData = shiftReg[W_OUT-1:0];
    end

  end else if (MODE == MODE_UNPACK) begin : g_unpack
    localparam int REG_W = NSLICE * W_OUT;
    localparam int PAD_W = REG_W - W_IN;
    logic [REG_W-1:0] shiftReg;

    if (HIGH_FIRST) begin : g_hi
      // zero fill sits at the bottom and is emitted last
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shiftReg <= '0;
        else if (strobes.capture) shiftReg <= REG_W'(inData) << PAD_W;
        else if (strobes.emit)    shiftReg <= shiftReg << W_OUT;
      end
      assign outData = shiftReg[REG_W-1 -: W_OUT];
    end else begin : g_lo
      // zero fill sits at the top and is emitted last
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shiftReg <= '0;
        else if (strobes.capture) shiftReg <= REG_W'(inData);
        else if (strobes.emit)    shiftReg <= shiftReg >> W_OUT;
      end
      assign outData = shiftReg[W_OUT-1:0];
    end

  end else begin : g_pass
    logic unusedPass;
    assign unusedPass = ^{strobes, clk, rstN};
    assign outData    = inData;
  end

endmodule

// File: rtl/stream_width_adapter.sv
`timescale 1ns/1ps
module stream_width_adapter
  import swa_pkg::*;
#(
  parameter int W_IN       = 8,
  parameter int W_OUT      = 16,
  parameter bit HIGH_FIRST = 1'b0,
  parameter bit PAD        = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [W_IN-1:0]  inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [W_OUT-1:0] outData
);

  localparam adaptMode_e MODE = (W_OUT > W_IN) ? MODE_PACK :
                                (W_OUT < W_IN) ? MODE_UNPACK : MODE_PASS;
  localparam int NSLICE = (MODE == MODE_PACK)   ? ceilDiv(W_OUT, W_IN) :
                          (MODE == MODE_UNPACK) ? ceilDiv(W_IN, W_OUT) : 1;
  localparam bit EXACT  = (MODE == MODE_PACK)   ? (W_OUT % W_IN == 0) :
                          (MODE == MODE_UNPACK) ? (W_IN % W_OUT == 0) : 1'b1;

  // R5: without padding, widths must divide one another
  if (!PAD && !EXACT) begin : g_bad_widths
    initial $error("stream_width_adapter: widths %0d and %0d need PAD", W_IN, W_OUT);
  end

  swaStrobes_t strobes;

  swa_control #(
    .MODE   (MODE),
    .NSLICE (NSLICE)
  ) control_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobes  (strobes)
  );

  swa_datapath #(
    .W_IN       (W_IN),
    .W_OUT      (W_OUT),
    .NSLICE     (NSLICE),
    .HIGH_FIRST (HIGH_FIRST),
    .MODE       (MODE)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inData  (inData),
    .outData (outData)
  );

  if (MODE != MODE_PASS) begin : g_hold_checks
    // R9: a stalled beat keeps its valid and its payload
    a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
      outValid && !outReady |=> outValid);
    a_r9_data_stable: assert property (@(posedge clk) disable iff (!rstN)
      outValid && !outReady |=> $stable(outData));
  end

endmodule

// File: tb/stream_width_adapter_tb_top.sv
`timescale 1ns/1ps
module stream_width_adapter_tb_case
  import swa_pkg::*;
#(
  parameter int W_IN       = 8,
  parameter int W_OUT      = 16,
  parameter bit HIGH_FIRST = 1'b0,
  parameter bit PAD        = 1'b0,
  parameter int NIN        = 40,
  parameter int SEED       = 5
) (
  input  logic clk,
  input  logic rstN,
  output int   nChecks,
  output int   nFails,
  output logic done
);

  localparam adaptMode_e MODE = (W_OUT > W_IN) ? MODE_PACK :
                                (W_OUT < W_IN) ? MODE_UNPACK : MODE_PASS;
  localparam int NS = (MODE == MODE_PACK)   ? ceilDiv(W_OUT, W_IN) :
                      (MODE == MODE_UNPACK) ? ceilDiv(W_IN, W_OUT) : 1;
  localparam int EXP_OUT = (MODE == MODE_PACK)   ? NIN / NS :
                           (MODE == MODE_UNPACK) ? NIN * NS : NIN;
  localparam int LIMIT = 6000;

  logic             inValid, inReady, outValid, outReady;
  logic [W_IN-1:0]  inData;
  logic [W_OUT-1:0] outData;

  stream_width_adapter #(
    .W_IN(W_IN), .W_OUT(W_OUT), .HIGH_FIRST(HIGH_FIRST), .PAD(PAD)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  logic [15:0] sent [64];
  logic [15:0] lfsr;
  int nIn, nOut;
  string tagData, tagFlow;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s (in %0d out %0d order %0d pad %0d) actual=%0h expected=%0h",
               tag, what, W_IN, W_OUT, HIGH_FIRST, PAD, act, exp);
    end
  endtask

  // expected output beat j, built bit by bit from the accepted input beats
  function automatic logic [W_OUT-1:0] expOut(input int j);
    logic [W_OUT-1:0] r;
    int beat, pos, c, w, s, p;
    r = '0;
    for (int b = 0; b < W_OUT; b++) begin
      if (MODE == MODE_PACK) begin
        if (!HIGH_FIRST) begin
          beat = j * NS + b / W_IN;
          pos  = b % W_IN;
        end else begin
          c    = b + NS * W_IN - W_OUT;
          beat = j * NS + NS - 1 - c / W_IN;
          pos  = c % W_IN;
        end
        r[b] = sent[beat][pos];
      end else if (MODE == MODE_UNPACK) begin
        w = j / NS;
        s = j % NS;
        if (!HIGH_FIRST) p = s * W_OUT + b;
        else             p = (NS - 1 - s) * W_OUT + b - (NS * W_OUT - W_IN);
        r[b] = (p >= 0 && p < W_IN) ? sent[w][p] : 1'b0;
      end else begin
        r[b] = sent[j][b];
      end
    end
    return r;
  endfunction

  initial begin
    bit inFire, outFire, prevStall;
    logic [W_OUT-1:0] prevData;
    nChecks = 0; nFails = 0; done = 1'b0;
    nIn = 0; nOut = 0; prevStall = 1'b0; prevData = '0;
    inValid = 1'b0; inData = '0; outReady = 1'b0;
    lfsr = 16'(SEED) | 16'h1;
    for (int k = 0; k < 64; k++)
      sent[k] = 16'((k * 40503 + SEED * 131) ^ (k << 7));

    tagData = (MODE == MODE_PACK) ? "R1" : (MODE == MODE_UNPACK) ? "R2" : "R6";
    tagData = {tagData, HIGH_FIRST ? "/R4" : "/R3"};
    if (PAD) tagData = {tagData, "/R5"};
    tagFlow = (MODE == MODE_PACK) ? "R7" : (MODE == MODE_UNPACK) ? "R8" : "R6";

    // R10: state held in reset
    @(negedge clk);
    check(outValid == 1'b0, "R10", "outValid in reset", outValid, 0);
    wait (rstN);
    @(negedge clk);
    check(outValid == 1'b0, "R10", "outValid after reset", outValid, 0);
    check(inReady == (MODE != MODE_PASS), "R10", "inReady after reset",
          inReady, (MODE != MODE_PASS));

    @(posedge clk); #1;
    inValid = 1'b1;
    inData  = sent[0][W_IN-1:0];

    for (int cyc = 0; cyc < LIMIT && !(nOut == EXP_OUT && nIn == NIN); cyc++) begin
      @(negedge clk);
      if (cyc == 20) begin
        // output held back for 20 cycles: count what got in
        check(nIn == ((MODE == MODE_PACK) ? NS : (MODE == MODE_UNPACK) ? 1 : 0),
              tagFlow, "beats taken with output blocked", nIn,
              (MODE == MODE_PACK) ? NS : (MODE == MODE_UNPACK) ? 1 : 0);
        check(inReady == 1'b0, tagFlow, "inReady while blocked", inReady, 0);
        check(outValid == 1'b1, tagFlow, "outValid while blocked", outValid, 1);
      end
      if (prevStall) begin
        check(outValid == 1'b1, "R9", "outValid after stall", outValid, 1);
        check(outData == prevData, "R9", "outData after stall", outData, prevData);
      end
      inFire  = inValid && inReady;
      outFire = outValid && outReady;
      if (MODE == MODE_PASS)
        check(inReady == outReady && outValid == inValid, "R6", "handshake pass-through",
              {inReady, outValid}, {outReady, inValid});
      if (outFire) begin
        check(outData == expOut(nOut), tagData, $sformatf("output beat %0d", nOut),
              outData, expOut(nOut));
        nOut++;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (inFire) nIn++;

      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cyc < 20) begin
        inValid  = (nIn < NIN);
        outReady = 1'b0;
      end else begin
        if (!(inValid && !inFire)) inValid = (nIn < NIN) && (lfsr[1:0] != 2'b00);
        outReady = (lfsr[6:4] < 3'd5);
      end
      if (nIn < NIN) inData = sent[nIn][W_IN-1:0];
    end

    check(nOut == EXP_OUT, tagData, "output beat count", nOut, EXP_OUT);
    check(nIn == NIN, tagFlow, "input beat count", nIn, NIN);
    inValid  = 1'b0;
    outReady = 1'b0;
    done = 1'b1;
  end

endmodule

module stream_width_adapter_tb_top;

  localparam int NCASE = 9;
  localparam int CW_IN  [NCASE] = '{8, 8, 16, 16, 4, 4, 10, 10, 8};
  localparam int CW_OUT [NCASE] = '{16, 16, 4, 4, 10, 10, 4, 4, 8};
  localparam int CHI    [NCASE] = '{0, 1, 0, 1, 0, 1, 0, 1, 0};
  localparam int CPAD   [NCASE] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};
  localparam int CNIN   [NCASE] = '{40, 40, 30, 30, 39, 39, 30, 30, 40};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int   caseChecks [NCASE];
  int   caseFails  [NCASE];
  logic caseDone   [NCASE];

  for (genvar g = 0; g < NCASE; g++) begin : g_case
    stream_width_adapter_tb_case #(
      .W_IN       (CW_IN[g]),
      .W_OUT      (CW_OUT[g]),
      .HIGH_FIRST (CHI[g] != 0),
      .PAD        (CPAD[g] != 0),
      .NIN        (CNIN[g]),
      .SEED       (g * 97 + 5)
    ) case_i (
      .clk     (clk),
      .rstN    (rstN),
      .nChecks (caseChecks[g]),
      .nFails  (caseFails[g]),
      .done    (caseDone[g])
    );
  end

  function automatic bit allDone();
    for (int g = 0; g < NCASE; g++) if (caseDone[g] !== 1'b1) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    int total, failed;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    for (int c = 0; c < 20000 && !allDone(); c++) @(posedge clk);
    total = 0;
    failed = 0;
    for (int g = 0; g < NCASE; g++) begin
      total  += caseChecks[g];
      failed += caseFails[g];
    end
    if (!allDone()) begin
      total++;
      failed++;
      $display("FAIL watchdog: run did not complete, actual=not done expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

endmodule